// File: doc/BRIEF.md
# Serial Receive Unit with Error Tracking

This block turns an asynchronous serial input into bytes for a processor to read. A clock enable arriving at eight times the baud rate drives the sampler. The sampler confirms each start edge halfway into the bit. It collects seven or eight data bits, least significant first, then an optional parity bit and a stop bit. Each finished character goes into a 64-entry queue, which a consumer drains through a show-ahead pop port.

Parity mismatches, bad stop bits, breaks and characters that arrive while the queue is full are each recorded in a sticky flag. A flag stays set until a clear pulse. The unit also drives three outputs that set the pace of the consumer and the sender:

- a data request once the fill reaches a programmable trigger;
- a timeout request when a few characters sit below the trigger and nothing new arrives;
- a ready-to-send output that drops at a programmable fill level when automatic flow control is enabled.

Top module: `rx_serial_unit`

## Requirements
- R1: After reset the fill count is 0, all four error flags are 0, the data request and the timeout request are 0, and `rts_out` is 1.
- R2: A frame is a low start bit, data bits least significant first, an optional parity bit and a high stop bit. The start bit counts only if the line is still low four oversample ticks after the falling edge was seen; a shorter low pulse stores nothing and sets no flag.
- R3: With `cfg_eight_bits` = 0, seven data bits are received and bit 7 of the stored byte is 0.
- R4: `cfg_parity_mode` selects the parity rule when parity is enabled: 0 odd, 1 even, 2 always 0, 3 always 1. A mismatch sets the sticky `err_parity` flag, and the byte is still stored.
- R5: A stop bit sampled low sets the sticky `err_frame` flag and the byte is still stored.
- R6: A frame in which every sampled bit, stop included, is low sets `err_break` and `err_frame` and stores nothing. Reception resumes only after the line returns high.
- R7: The queue holds 64 bytes in arrival order. `fill_count` is a 7-bit count. `pop_data` shows the oldest byte. A pop while empty has no effect.
- R8: A byte that completes while the queue is full is dropped. Its arrival sets the sticky `err_overflow` flag and the fill count stays at 64.
- R9: A `fifo_flush` pulse empties the queue. An `err_clear` pulse clears all four flags. An error event in the same cycle as the clear wins over it.
- R10: `data_req` is 1 exactly when the fill count is nonzero and at least `cfg_rx_trig`.
- R11: `timeout_req` rises when at least one byte is held below the trigger level and four character times pass with no arrival and no pop. Any pop, arrival or flush clears it.
- R12: With `cfg_flow_en` = 1, `rts_out` is 0 while the fill count is at least `cfg_flow_lvl`. With `cfg_flow_en` = 0, `rts_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversample enable, eight per bit time |
| rx_in | input | 1 | Serial line, idle high |
| cfg_enable | input | 1 | Receiver enable |
| cfg_eight_bits | input | 1 | 1 selects eight data bits, 0 selects seven |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_parity_mode | input | 2 | 0 odd, 1 even, 2 always 0, 3 always 1 |
| cfg_flow_en | input | 1 | Automatic ready-to-send control |
| cfg_rx_trig | input | 5 | Data request level |
| cfg_flow_lvl | input | 5 | Fill level that drops `rts_out` |
| fifo_flush | input | 1 | Empty the queue |
| err_clear | input | 1 | Clear the sticky flags |
| pop | input | 1 | Remove the oldest byte |
| pop_data | output | 8 | Oldest byte (show-ahead) |
| fill_count | output | 7 | Bytes held |
| data_req | output | 1 | Fill reached the trigger |
| timeout_req | output | 1 | Idle data below the trigger |
| rts_out | output | 1 | Sender may transmit |
| err_parity | output | 1 | Sticky parity mismatch |
| err_frame | output | 1 | Sticky bad stop bit |
| err_overflow | output | 1 | Sticky dropped byte |
| err_break | output | 1 | Sticky break seen |

## Verification
The checker watches the queue on every cycle:
- the fill moves by at most one per cycle and a flush empties it;
- a pop on empty and a break frame leave the fill untouched;
- a drop into a full queue raises the overflow flag;
- the parity flag stays set until a clear;
- the two requests never both stand, and an arrival or a pop clears the timeout.

The bench scenarios alone show the line-level behaviour: bit order and the 7-bit mode, every parity rule, the rejected glitch, break framing, and the exact trigger, flow-control and timeout thresholds.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
  } rxs_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       par_bad;
    logic       frame_bad;
    logic       brk;
  } rxs_char_t;

  // Expected parity bit: 0 odd, 1 even, 2 always 0, 3 always 1.
  function automatic logic parity_bit(logic [7:0] d, logic eight, logic [1:0] mode);
    logic x;
    x = eight ? ^d : ^d[6:0];
    case (mode)
      2'd0:    return ~x;
      2'd1:    return x;
      2'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // Oversample ticks in one character: start, data, optional parity, stop.
  function automatic int char_ticks(int ovs, logic eight, logic par_en);
    return ovs * (2 + (eight ? 8 : 7) + (par_en ? 1 : 0));
  endfunction

  // Fill at or above a level; both are widened so any width pair compares.
  function automatic logic at_level(logic [15:0] fill, logic [15:0] lvl);
    return fill >= lvl;
  endfunction

endpackage

// File: rtl/rxs_sampler.sv
module rxs_sampler
  import rxs_pkg::*;
#(
  parameter int OVS = 8
)(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      tick,
  input  logic      rx_s,
  input  logic      eight,
  input  logic      par_en,
  input  logic [1:0] par_mode,
  output logic      char_evt,
  output rxs_char_t char_out
);
  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] MID = PH_W'(OVS / 2);

  rxs_state_e      state;
  logic [PH_W-1:0] phase;
  logic [2:0]      idx;
  logic [7:0]      shreg;
  logic            pbit;
  logic [2:0]      last_idx;
  logic            mid_tick;

  assign last_idx = eight ? 3'd7 : 3'd6;
  assign mid_tick = tick && (phase == MID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= '0;
      idx      <= '0;
      shreg    <= '0;
      pbit     <= 1'b0;
      char_evt <= 1'b0;
      char_out <= '0;
    end else begin
      char_evt <= 1'b0;
      if (!en) begin
        state <= ST_IDLE;
      end else if (state == ST_HOLD) begin
        if (rx_s) state <= ST_IDLE;
      end else if (state == ST_IDLE) begin
        if (tick && !rx_s) begin
          state <= ST_START;
          phase <= PH_W'(1);
        end
      end else if (tick) begin
        phase <= phase + PH_W'(1);
        if (mid_tick) begin
          case (state)
            ST_START: begin
              if (rx_s) state <= ST_IDLE;
              else begin
                state <= ST_DATA;
                idx   <= '0;
                shreg <= '0;
                pbit  <= 1'b0;
              end
            end
            ST_DATA: begin
              shreg[idx] <= rx_s;
              idx        <= idx + 3'd1;
              if (idx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
            end
            ST_PAR: begin
              pbit  <= rx_s;
              state <= ST_STOP;
            end
            default: begin
              char_evt           <= 1'b1;
              char_out.data      <= shreg;
              char_out.par_bad   <= par_en && (pbit != parity_bit(shreg, eight, par_mode));
              char_out.frame_bad <= !rx_s;
              char_out.brk       <= !rx_s && (shreg == 8'd0) && !pbit;
              state              <= rx_s ? ST_IDLE : ST_HOLD;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     push,
  input  logic [DW-1:0]            din,
  input  logic                     pop,
  output logic [DW-1:0]            dout,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (count != '0);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxs_pacer.sv
module rxs_pacer
  import rxs_pkg::*;
#(
  parameter int OVS      = 8,
  parameter int TO_CHARS = 4,
  parameter int CW       = 7,
  parameter int LVL_W    = 5
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CW-1:0]    fill,
  input  logic [LVL_W-1:0] trig,
  input  logic [LVL_W-1:0] flow_lvl,
  input  logic             flow_en,
  input  logic             eight,
  input  logic             par_en,
  input  logic             arrive,
  input  logic             pop,
  input  logic             flush,
  output logic             data_req,
  output logic             timeout_req,
  output logic             rts
);
  localparam int TO_MAX = TO_CHARS * OVS * 11;
  localparam int TO_W   = $clog2(TO_MAX + 1);

  logic [TO_W-1:0] idle_cnt, limit;
  logic            expired;

  assign limit    = TO_W'(TO_CHARS * char_ticks(OVS, eight, par_en));
  assign expired  = idle_cnt >= limit;
  assign data_req = (fill != '0) && at_level(16'(fill), 16'(trig));
  assign timeout_req = expired && (fill != '0) && !data_req;
  assign rts      = !flow_en || !at_level(16'(fill), 16'(flow_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_cnt <= '0;
    else if (arrive || pop || flush || fill == '0) idle_cnt <= '0;
    else if (tick && !expired) idle_cnt <= idle_cnt + TO_W'(1);
  end
endmodule

// File: rtl/rx_serial_unit.sv
module rx_serial_unit
  import rxs_pkg::*;
#(
  parameter int OVS      = 8,
  parameter int DEPTH    = 64,
  parameter int LVL_W    = 5,
  parameter int TO_CHARS = 4
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   os_tick,
  input  logic                   rx_in,
  input  logic                   cfg_enable,
  input  logic                   cfg_eight_bits,
  input  logic                   cfg_parity_en,
  input  logic [1:0]             cfg_parity_mode,
  input  logic                   cfg_flow_en,
  input  logic [LVL_W-1:0]       cfg_rx_trig,
  input  logic [LVL_W-1:0]       cfg_flow_lvl,
  input  logic                   fifo_flush,
  input  logic                   err_clear,
  input  logic                   pop,
  output logic [7:0]             pop_data,
  output logic [$clog2(DEPTH):0] fill_count,
  output logic                   data_req,
  output logic                   timeout_req,
  output logic                   rts_out,
  output logic                   err_parity,
  output logic                   err_frame,
  output logic                   err_overflow,
  output logic                   err_break
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic      rx_meta, rx_sync;
  logic      byte_evt, store, fifo_full;
  rxs_char_t frm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_sync <= 1'b1;
    end else begin
      rx_meta <= rx_in;
      rx_sync <= rx_meta;
    end
  end

  rxs_sampler #(.OVS(OVS)) u_smp (
    .clk(clk), .rst_n(rst_n), .en(cfg_enable), .tick(os_tick), .rx_s(rx_sync),
    .eight(cfg_eight_bits), .par_en(cfg_parity_en), .par_mode(cfg_parity_mode),
    .char_evt(byte_evt), .char_out(frm)
  );

  assign store = byte_evt && !frm.brk;

  rxs_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .push(store), .din(frm.data),
    .pop(pop), .dout(pop_data), .count(fill_count), .full(fifo_full)
  );

  rxs_pacer #(.OVS(OVS), .TO_CHARS(TO_CHARS), .CW(CW), .LVL_W(LVL_W)) u_pace (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .fill(fill_count), .trig(cfg_rx_trig),
    .flow_lvl(cfg_flow_lvl), .flow_en(cfg_flow_en), .eight(cfg_eight_bits),
    .par_en(cfg_parity_en), .arrive(byte_evt), .pop(pop), .flush(fifo_flush),
    .data_req(data_req), .timeout_req(timeout_req), .rts(rts_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_parity   <= 1'b0;
      err_frame    <= 1'b0;
      err_overflow <= 1'b0;
      err_break    <= 1'b0;
    end else begin
      err_parity   <= (err_parity   && !err_clear) || (store && frm.par_bad);
      err_frame    <= (err_frame    && !err_clear) || (byte_evt && frm.frame_bad);
      err_overflow <= (err_overflow && !err_clear) || (store && fifo_full);
      err_break    <= (err_break    && !err_clear) || (byte_evt && frm.brk);
    end
  end
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int DEPTH = 64
)(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   fifo_flush,
  input logic                   pop,
  input logic                   err_clear,
  input logic [$clog2(DEPTH):0] fill_count,
  input logic                   byte_evt,
  input logic                   brk_bit,
  input logic                   fifo_full,
  input logic                   err_overflow,
  input logic                   err_parity,
  input logic                   data_req,
  input logic                   timeout_req
);
  localparam int CW = $clog2(DEPTH) + 1;

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_flush |=> ({1'b0, fill_count} <= {1'b0, $past(fill_count)} + (CW+1)'(1)) &&
                    ({1'b0, fill_count} + (CW+1)'(1) >= {1'b0, $past(fill_count)})); // R7

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop && fill_count == '0 && !byte_evt && !fifo_flush |=> fill_count == '0); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> fill_count == '0); // R9

  AST_BREAK_NOSTORE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_evt && brk_bit && !pop && !fifo_flush |=> $stable(fill_count)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    byte_evt && !brk_bit && fifo_full |=> err_overflow); // R8

  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity && !err_clear |=> err_parity); // R4

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_req && timeout_req)); // R10

  AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    byte_evt || pop || fifo_flush |=> !timeout_req); // R11
endmodule

bind rx_serial_unit rxs_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_flush(fifo_flush), .pop(pop), .err_clear(err_clear),
  .fill_count(fill_count), .byte_evt(byte_evt), .brk_bit(frm.brk), .fifo_full(fifo_full),
  .err_overflow(err_overflow), .err_parity(err_parity), .data_req(data_req),
  .timeout_req(timeout_req)
);

// File: tb/tb_rx_serial_unit.sv
module tb_rx_serial_unit;
  localparam int BIT_CLKS = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic os_tick;
  logic rx_in = 1'b1;
  logic cfg_enable = 1'b1, cfg_eight_bits = 1'b1, cfg_parity_en = 1'b0;
  logic [1:0] cfg_parity_mode = 2'd0;
  logic cfg_flow_en = 1'b0;
  logic [4:0] cfg_rx_trig = 5'd16, cfg_flow_lvl = 5'd20;
  logic fifo_flush = 1'b0, err_clear = 1'b0;
  logic mon_pop = 1'b0, tst_pop = 1'b0, mon_on = 1'b1;
  logic pop;
  logic [7:0] pop_data;
  logic [6:0] fill_count;
  logic data_req, timeout_req, rts_out;
  logic err_parity, err_frame, err_overflow, err_break;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign os_tick = (tdiv == 2'd3);
  assign pop = mon_pop | tst_pop;

  rx_serial_unit dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
    .cfg_enable(cfg_enable), .cfg_eight_bits(cfg_eight_bits),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_mode(cfg_parity_mode),
    .cfg_flow_en(cfg_flow_en), .cfg_rx_trig(cfg_rx_trig), .cfg_flow_lvl(cfg_flow_lvl),
    .fifo_flush(fifo_flush), .err_clear(err_clear), .pop(pop), .pop_data(pop_data),
    .fill_count(fill_count), .data_req(data_req), .timeout_req(timeout_req),
    .rts_out(rts_out), .err_parity(err_parity), .err_frame(err_frame),
    .err_overflow(err_overflow), .err_break(err_break)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops each byte as it appears and compares with the scoreboard.
  always @(negedge clk) begin
    if (mon_pop) mon_pop = 1'b0;
    else if (mon_on && rst_n && fill_count != 7'd0) begin
      if (exp_q.size() == 0) check("R7 unexpected byte", int'(pop_data), -1);
      else check("R2 R7 byte order", int'(pop_data), int'(exp_q.pop_front()));
      mon_pop = 1'b1;
    end
  end

  task automatic line(input logic v);
    @(negedge clk) rx_in = v;
    repeat (BIT_CLKS - 1) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop, input bit keep);
    int nb, ones;
    logic p;
    nb = cfg_eight_bits ? 8 : 7;
    ones = 0;
    for (int i = 0; i < nb; i++) ones += int'(d[i]);
    case (cfg_parity_mode)
      2'd0: p = (ones % 2 == 0);
      2'd1: p = (ones % 2 == 1);
      2'd2: p = 1'b0;
      default: p = 1'b1;
    endcase
    if (keep) exp_q.push_back(cfg_eight_bits ? d : {1'b0, d[6:0]});
    line(1'b0);
    for (int i = 0; i < nb; i++) line(d[i]);
    if (cfg_parity_en) line(p ^ bad_par);
    line(!bad_stop);
  endtask

  task automatic drain();
    for (int i = 0; i < 4000 && (fill_count != 7'd0 || exp_q.size() != 0); i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R7 scoreboard empty", exp_q.size(), 0);
  endtask

  task automatic clear_flags();
    @(negedge clk) err_clear = 1'b1;
    @(negedge clk) err_clear = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 fill", fill_count, 0);
    check("R1 flags", {err_parity, err_frame, err_overflow, err_break}, 0);
    check("R1 requests", {data_req, timeout_req}, 0);
    check("R1 rts", rts_out, 1);

    // R2 eight-bit frames, LSB first
    send(8'hA5, 0, 0, 1); send(8'h3C, 0, 0, 1); send(8'h81, 0, 0, 1);
    send(8'h00, 0, 0, 1); send(8'hFF, 0, 0, 1);
    drain();
    // R2 short glitch is not a start bit
    @(negedge clk) rx_in = 1'b0;
    repeat (4) @(negedge clk);
    rx_in = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    check("R2 glitch fill", fill_count, 0);
    check("R2 glitch flags", {err_parity, err_frame, err_overflow, err_break}, 0);

    // R3 seven-bit mode
    cfg_eight_bits = 1'b0;
    send(8'hD5, 0, 0, 1); send(8'h7F, 0, 0, 1);
    drain();
    cfg_eight_bits = 1'b1;

    // R4 parity rules
    cfg_parity_en = 1'b1;
    cfg_parity_mode = 2'd1; send(8'h35, 0, 0, 1);
    check("R4 even ok", err_parity, 0);
    cfg_parity_mode = 2'd0; send(8'h35, 0, 0, 1);
    check("R4 odd ok", err_parity, 0);
    send(8'h6E, 1, 0, 1);
    check("R4 odd mismatch", err_parity, 1);
    clear_flags();
    check("R9 clear", err_parity, 0);
    cfg_parity_mode = 2'd2; send(8'hC3, 0, 0, 1);
    cfg_parity_mode = 2'd3; send(8'h1E, 0, 0, 1);
    check("R4 space mark ok", err_parity, 0);
    cfg_parity_mode = 2'd3; send(8'h44, 1, 0, 1);
    check("R4 mark mismatch", err_parity, 1);
    drain();
    clear_flags();
    cfg_parity_en = 1'b0; cfg_parity_mode = 2'd0;

    // R5 bad stop bit
    send(8'h5A, 0, 1, 1);
    line(1'b1);
    check("R5 frame flag", err_frame, 1);
    check("R5 no break", err_break, 0);
    drain();
    clear_flags();

    // R6 break
    for (int i = 0; i < 12; i++) line(1'b0);
    line(1'b1); line(1'b1);
    check("R6 break flags", {err_break, err_frame}, 2'b11);
    check("R6 nothing stored", fill_count, 0);
    clear_flags();
    check("R9 all cleared", {err_parity, err_frame, err_overflow, err_break}, 0);
    send(8'h96, 0, 0, 1);
    drain();

    // R10 trigger level
    mon_on = 1'b0; cfg_rx_trig = 5'd3;
    send(8'h11, 0, 0, 1); send(8'h22, 0, 0, 1);
    check("R7 fill two", fill_count, 2);
    check("R10 below trigger", data_req, 0);
    send(8'h33, 0, 0, 1);
    check("R10 at trigger", data_req, 1);
    mon_on = 1'b1;
    drain();
    check("R10 empty", data_req, 0);
    cfg_rx_trig = 5'd16;

    // R11 idle timeout
    mon_on = 1'b0;
    send(8'h4D, 0, 0, 1);
    repeat (600) @(negedge clk);
    check("R11 early", timeout_req, 0);
    repeat (900) @(negedge clk);
    check("R11 fired", timeout_req, 1);
    check("R10 no data_req", data_req, 0);
    mon_on = 1'b1;
    drain();
    check("R11 cleared by pop", timeout_req, 0);

    // R12 automatic flow control
    mon_on = 1'b0; cfg_flow_en = 1'b1; cfg_flow_lvl = 5'd5;
    for (int i = 0; i < 4; i++) send(8'(8'h60 + i), 0, 0, 1);
    check("R12 below level", rts_out, 1);
    send(8'h64, 0, 0, 1);
    check("R12 at level", rts_out, 0);
    @(negedge clk) cfg_flow_en = 1'b0;
    @(negedge clk);
    check("R12 disabled", rts_out, 1);
    cfg_flow_en = 1'b1;
    mon_on = 1'b1;
    drain();
    check("R12 drained", rts_out, 1);
    cfg_flow_en = 1'b0;

    // R8 overflow
    mon_on = 1'b0;
    for (int i = 0; i < 64; i++) send(8'(i * 3 + 1), 0, 0, 1);
    check("R7 full count", fill_count, 64);
    check("R8 no flag yet", err_overflow, 0);
    send(8'hEE, 0, 0, 0);
    check("R8 count held", fill_count, 64);
    check("R8 flag", err_overflow, 1);
    mon_on = 1'b1;
    drain();
    clear_flags();

    // R9 flush
    mon_on = 1'b0;
    send(8'hA1, 0, 0, 0); send(8'hA2, 0, 0, 0); send(8'hA3, 0, 0, 0);
    check("R9 before flush", fill_count, 3);
    @(negedge clk) fifo_flush = 1'b1;
    @(negedge clk) fifo_flush = 1'b0;
    check("R9 after flush", fill_count, 0);

    // R7 pop on empty is ignored
    @(negedge clk) tst_pop = 1'b1;
    repeat (3) @(negedge clk);
    tst_pop = 1'b0;
    check("R7 pop empty", fill_count, 0);
    mon_on = 1'b1;
    send(8'h5C, 0, 0, 1);
    drain();

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule